// File: doc/BRIEF.md
# Display serial bus master with data/command pin

This block drives a small display controller over a four-wire serial bus: serial clock, serial data out, chip select, and a separate data/command line. Each transaction opens with one command byte, sent while the data/command line is low. A write then streams its parameter bytes with the line high. A read clocks in a requested number of response bytes on the serial data input and delivers them as a byte stream. SPI mode 0 is used throughout: the clock idles low, data is launched after a falling edge and sampled on the rising edge, and bits go most significant first.

Three clock rates are derived from the system clock by half-period counters:
- **Fast write rate:** used for long pixel payloads.
- **Command rate:** used for the command byte and for payloads of 64 bytes or fewer.
- **Read rate:** capped at half the write rate and at a fixed ceiling.

After a memory-write command (0x2C), the byte stream is taken as little-endian 16-bit words and each word is shifted high byte first. Two status-type reads, display identification (0x04) and display status (0x09), have a response that begins with one dummy clock. For these the block captures one extra byte and shifts the result back by one bit.

A request is given as a one-cycle `start` with the command, a read flag and a length. Payload bytes are pulled with `tx_take`. The block answers with `done`, or with `err` if it rejects the request.

Top module: `disp_spi_dc_master`

## Requirements
- R1: The command byte is shifted MSB first with `dc` low, chip select low and `sclk` idling low, and `mosi` is held stable while `sclk` is high.
- R2: On a write, the parameter bytes follow the command byte in stream order with `dc` high. One `tx_take` cycle consumes exactly one `tx_data` byte.
- R3: `cs_n` goes low once per transaction and stays low until the last bit has ended. `done` then pulses for one cycle with `cs_n` already high.
- R4: On a write, the command byte and any payload of 64 bytes or fewer run at an `sclk` half period of 10 system clocks at the defaults. A payload longer than 64 bytes runs at 3 system clocks per half period.
- R5: A read of N bytes sends only the command byte, then clocks N bytes in with `mosi` and `dc` low. Each byte is presented once on `rx_data` with a one-cycle `rx_valid`. The whole read runs at a half period of 50 system clocks at the defaults.
- R6: For command 0x2C, each pair of stream bytes (first, second) is shifted as the 16-bit word {second, first}, MSB first. An odd last byte is shifted alone.
- R7: For read commands 0x04 and 0x09, N+1 raw bytes are captured, and output byte i equals ((raw[i] << 1) | (raw[i+1] >> 7)) truncated to 8 bits.
- R8: A read of 0x04 with a length other than 3, or of 0x09 with a length other than 4, is rejected. `err` pulses, `done` does not, and the bus stays idle.
- R9: A read request with a length of zero is rejected in the same way as R8.
- R10: A write with a length of zero sends only the command byte and then pulses `done`.
- R11: Out of reset, `cs_n` is high, `sclk`, `dc`, `done`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request strobe, taken when idle |
| req_cmd | input | 8 | Command byte |
| req_read | input | 1 | 1 for a read, 0 for a write |
| req_len | input | LEN_W | Payload or response length in bytes |
| tx_data | input | 8 | Next payload byte, valid whenever `tx_take` is high |
| tx_take | output | 1 | The block consumes `tx_data` in this cycle |
| rx_data | output | 8 | Received response byte |
| rx_valid | output | 1 | `rx_data` is valid for this cycle |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | Transaction finished |
| err | output | 1 | Request rejected |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |
| dc | output | 1 | Data/command select, low for command |

## Verification
The assertions assume that `start` is raised only while `busy` is low. They also assume that `miso` changes only while `sclk` is low or at the rising edge itself. The bench's responder model updates its bit only after each rising edge of `sclk`. Each request is issued only after the previous one has ended in `done` or `err`, so no request arrives during a transaction.

// File: rtl/disp_spi_dc_master.sv
module disp_spi_dc_master #(
  parameter int CLK_HZ       = 200_000_000,
  parameter int WRITE_HZ     = 40_000_000,
  parameter int CMD_HZ       = 10_000_000,
  parameter int READ_CEIL_HZ = 2_000_000,
  parameter int SHORT_MAX    = 64,
  parameter int LEN_W        = 16,
  parameter logic [7:0] OP_MEMWR  = 8'h2C,
  parameter logic [7:0] OP_ID     = 8'h04,
  parameter logic [7:0] OP_STATUS = 8'h09
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       req_cmd,
  input  logic             req_read,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       tx_data,
  output logic             tx_take,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             cs_n,
  output logic             dc
);
  localparam int CMD_EFF   = (CMD_HZ < WRITE_HZ) ? CMD_HZ : WRITE_HZ;
  localparam int RD_EFF    = (WRITE_HZ / 2 < READ_CEIL_HZ) ? WRITE_HZ / 2 : READ_CEIL_HZ;
  localparam int FAST_HALF = (CLK_HZ + 2 * WRITE_HZ - 1) / (2 * WRITE_HZ);
  localparam int CMD_HALF  = (CLK_HZ + 2 * CMD_EFF - 1) / (2 * CMD_EFF);
  localparam int RD_HALF   = (CLK_HZ + 2 * RD_EFF - 1) / (2 * RD_EFF);
  localparam int HW        = $clog2(RD_HALF + 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_LOAD, S_DATA, S_RD, S_END} st_t;

  st_t            st;
  logic [HW-1:0]  hc, half_r;
  logic [4:0]     nbit;
  logic [15:0]    sh;
  logic [LEN_W:0] left;
  logic           rd, wide, skew, first_raw, take_hi, short_r;
  logic [7:0]     lo, rxsh, prev;

  wire shifting = (st == S_CMD) || (st == S_DATA) || (st == S_RD);
  wire tick     = (hc == half_r - HW'(1));
  wire is_skew  = (req_cmd == OP_ID) || (req_cmd == OP_STATUS);
  wire bad_req  = req_read && ((req_len == '0) ||
                  ((req_cmd == OP_ID) && (req_len != LEN_W'(3))) ||
                  ((req_cmd == OP_STATUS) && (req_len != LEN_W'(4))));
  wire [7:0] raw = {rxsh[6:0], miso};

  assign mosi    = sh[15];
  assign busy    = (st != S_IDLE);
  assign tx_take = (st == S_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hc <= '0; half_r <= HW'(CMD_HALF); nbit <= '0; sh <= '0;
      left <= '0; rd <= 1'b0; wide <= 1'b0; skew <= 1'b0; first_raw <= 1'b0;
      take_hi <= 1'b0; short_r <= 1'b0; lo <= '0; rxsh <= '0; prev <= '0;
      rx_data <= '0; rx_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
      sclk <= 1'b0; cs_n <= 1'b1; dc <= 1'b0;
    end else begin
      done <= 1'b0; err <= 1'b0; rx_valid <= 1'b0;
      if (shifting) begin
        if (!tick) begin
          hc <= hc + HW'(1);
        end else begin
          hc <= '0;
          sclk <= ~sclk;
          if (!sclk) begin
            if (st == S_RD) rxsh <= raw;
          end else begin
            nbit <= nbit - 5'd1;
            sh   <= {sh[14:0], 1'b0};
            if (nbit == 5'd1) begin
              case (st)
                S_CMD: begin
                  if (rd) begin
                    st <= S_RD; nbit <= 5'd8;
                  end else if (left == '0) begin
                    st <= S_END;
                  end else begin
                    st <= S_LOAD; dc <= 1'b1;
                    half_r <= short_r ? HW'(CMD_HALF) : HW'(FAST_HALF);
                  end
                end
                S_DATA: st <= (left == '0) ? S_END : S_LOAD;
                default: begin
                  prev <= rxsh;
                  if (!skew) begin
                    rx_data <= rxsh; rx_valid <= 1'b1;
                  end else if (first_raw) begin
                    first_raw <= 1'b0;
                  end else begin
                    rx_data <= {prev[6:0], rxsh[7]}; rx_valid <= 1'b1;
                  end
                  left <= left - 1'b1;
                  if (left == (LEN_W+1)'(1)) st <= S_END;
                  else nbit <= 5'd8;
                end
              endcase
            end
          end
        end
      end else begin
        case (st)
          S_IDLE: if (start) begin
            if (bad_req) begin
              err <= 1'b1;
            end else begin
              st <= S_CMD; cs_n <= 1'b0; dc <= 1'b0; hc <= '0;
              sh <= {req_cmd, 8'h00}; nbit <= 5'd8;
              rd <= req_read;
              skew <= req_read && is_skew;
              first_raw <= 1'b1;
              wide <= !req_read && (req_cmd == OP_MEMWR);
              short_r <= (req_len <= LEN_W'(SHORT_MAX));
              half_r <= req_read ? HW'(RD_HALF) : HW'(CMD_HALF);
              left <= {1'b0, req_len} + (LEN_W+1)'(req_read && is_skew);
            end
          end
          S_LOAD: begin
            hc <= '0;
            left <= left - 1'b1;
            if (take_hi) begin
              sh <= {tx_data, lo}; nbit <= 5'd16; take_hi <= 1'b0; st <= S_DATA;
            end else if (wide && left >= (LEN_W+1)'(2)) begin
              lo <= tx_data; take_hi <= 1'b1;
            end else begin
              sh <= {tx_data, 8'h00}; nbit <= 5'd8; st <= S_DATA;
            end
          end
          S_END: begin
            cs_n <= 1'b1; dc <= 1'b0; done <= 1'b1; st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/disp_spi_dc_master_chk.sv
module disp_spi_dc_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic mosi,
  input logic cs_n,
  input logic dc,
  input logic done,
  input logic err,
  input logic rx_valid,
  input logic busy
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R1
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R1
  AST_FRAME_OPENS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> !dc); // R1
  AST_DC_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    dc |-> !cs_n); // R2
  AST_DONE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !err)); // R3
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !busy)); // R8
  AST_RX_NO_DC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!dc && !cs_n)); // R5
endmodule

bind disp_spi_dc_master disp_spi_dc_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .dc(dc),
  .done(done), .err(err), .rx_valid(rx_valid), .busy(busy)
);

// File: tb/disp_spi_dc_master_test.sv
`timescale 1ns/1ps
module disp_spi_dc_master_test;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, req_read = 1'b0;
  logic [7:0] req_cmd = 8'h00;
  logic [15:0] req_len = 16'd0;
  logic [7:0] tx_data, rx_data;
  logic tx_take, rx_valid, busy, done, err, sclk, mosi, miso, cs_n, dc;

  always #2.5 clk = ~clk;

  disp_spi_dc_master uut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_cmd(req_cmd), .req_read(req_read),
    .req_len(req_len), .tx_data(tx_data), .tx_take(tx_take), .rx_data(rx_data),
    .rx_valid(rx_valid), .busy(busy), .done(done), .err(err), .sclk(sclk),
    .mosi(mosi), .miso(miso), .cs_n(cs_n), .dc(dc)
  );

  int n_tests = 0, n_fail = 0;
  logic [7:0] pay [0:127];
  int tp_total = 0, tp0 = 0;
  assign tx_data = pay[(tp_total - tp0) & 127];
  always @(posedge clk) if (tx_take) tp_total <= tp_total + 1;

  logic [63:0] rbits = '0;
  int rc = 0, ncap = 0, bc = 0, cs_falls = 0;
  logic [7:0] acc = 8'h00;
  logic [7:0] cap_b [0:255];
  logic       cap_dc [0:255];
  assign miso = (rc >= 8 && rc < 72) ? rbits[63 - (rc - 8)] : 1'b0;

  always begin
    @(negedge cs_n);
    cs_falls++; ncap = 0; bc = 0; rc = 0;
    while (!cs_n) begin
      @(posedge sclk or posedge cs_n);
      if (!cs_n && sclk) begin
        acc = {acc[6:0], mosi};
        bc++; rc++;
        if (bc == 8) begin
          cap_b[ncap & 255] = acc; cap_dc[ncap & 255] = dc; ncap++; bc = 0;
        end
      end
    end
  end

  int hrun = 0, last_hi = 0;
  always @(negedge clk) begin
    if (sclk) hrun++;
    else begin
      if (hrun != 0) last_hi = hrun;
      hrun = 0;
    end
  end

  logic [7:0] rxb [0:255];
  int nrx = 0, nrx0 = 0, csf0 = 0;
  always @(negedge clk) if (rx_valid) begin rxb[nrx & 255] = rx_data; nrx++; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] c, input bit r, input int n,
                     output bit got_done, output bit got_err);
    @(negedge clk);
    req_cmd = c; req_read = r; req_len = 16'(n);
    tp0 = tp_total; nrx0 = nrx; csf0 = cs_falls;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 1'b0; got_err = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (done) got_done = 1'b1;
      if (err) got_err = 1'b1;
      if (got_done || got_err) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cs_n == 1'b1, "R11 cs_n", int'(cs_n), 1);
    chk(!sclk && !dc, "R11 sclk/dc", int'({sclk, dc}), 0);
    chk(!busy && !done && !err, "R11 busy/done/err", int'({busy, done, err}), 0);
  endtask

  task automatic t_write_short;
    bit d, e;
    pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'h0F;
    run(8'h36, 1'b0, 3, d, e);
    chk(d && !e, "R3 done", int'({d, e}), 2);
    chk(cs_falls == csf0 + 1, "R3 single frame", cs_falls - csf0, 1);
    chk(ncap == 4, "R2 byte count", ncap, 4);
    chk(cap_b[0] == 8'h36 && cap_dc[0] == 1'b0, "R1 command byte", int'({cap_dc[0], cap_b[0]}), 'h036);
    for (int i = 0; i < 3; i++)
      chk(cap_b[i+1] == pay[i] && cap_dc[i+1], "R2 param byte", int'({cap_dc[i+1], cap_b[i+1]}), int'({1'b1, pay[i]}));
    chk(last_hi == 10, "R4 short rate", last_hi, 10);
  endtask

  task automatic t_write_long;
    bit d, e;
    int bad = 0;
    for (int i = 0; i < 70; i++) pay[i] = 8'(i * 7 + 3);
    run(8'h3C, 1'b0, 70, d, e);
    chk(d && ncap == 71, "R2 long count", ncap, 71);
    for (int i = 0; i < 70; i++) if (cap_b[i+1] != pay[i] || !cap_dc[i+1]) bad++;
    chk(bad == 0, "R2 long order", bad, 0);
    chk(last_hi == 3, "R4 long rate", last_hi, 3);
  endtask

  task automatic t_memwr(input int n);
    bit d, e;
    int bad = 0;
    for (int i = 0; i < n; i++) pay[i] = 8'h10 + 8'(i);
    run(8'h2C, 1'b0, n, d, e);
    chk(d && ncap == n + 1, "R6 count", ncap, n + 1);
    for (int i = 0; i < n; i++) begin
      int src = ((i % 2) == 0) ? ((i + 1 < n) ? i + 1 : i) : i - 1;
      if (cap_b[i+1] != pay[src]) bad++;
    end
    chk(bad == 0, "R6 word swap", bad, 0);
  endtask

  task automatic t_write_zero;
    bit d, e;
    run(8'h29, 1'b0, 0, d, e);
    chk(d && !e, "R10 done", int'({d, e}), 2);
    chk(ncap == 1 && cap_b[0] == 8'h29, "R10 command only", ncap, 1);
  endtask

  task automatic t_read(input logic [7:0] c, input int n, input logic [39:0] raw, input bit sk);
    bit d, e;
    int bad = 0;
    rbits = {raw, 24'h0};
    run(c, 1'b1, n, d, e);
    chk(d && !e, "R5 read done", int'({d, e}), 2);
    chk(nrx - nrx0 == n, "R5 rx count", nrx - nrx0, n);
    chk(cap_b[0] == c && ncap == 1 + n + int'(sk), "R5 frame bytes", ncap, 1 + n + int'(sk));
    for (int i = 1; i < ncap; i++) if (cap_b[i] != 8'h00 || cap_dc[i]) bad++;
    chk(bad == 0, "R5 mosi/dc low", bad, 0);
    chk(last_hi == 50, "R5 read rate", last_hi, 50);
    for (int i = 0; i < n; i++) begin
      logic [7:0] r0, r1, ex;
      r0 = raw[39 - 8*i -: 8];
      r1 = raw[31 - 8*i -: 8];
      ex = sk ? 8'((r0 << 1) | (r1 >> 7)) : r0;
      chk(rxb[(nrx0 + i) & 255] == ex, sk ? "R7 realign" : "R5 rx data", int'(rxb[(nrx0 + i) & 255]), int'(ex));
    end
  endtask

  task automatic t_reject(input logic [7:0] c, input int n, input string req);
    bit d, e;
    run(c, 1'b1, n, d, e);
    chk(e && !d, req, int'({d, e}), 1);
    chk(cs_falls == csf0 && cs_n, req, cs_falls - csf0, 0);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_write_short();
    t_write_long();
    t_memwr(6);
    t_memwr(5);
    t_write_zero();
    t_read(8'h0A, 2, 40'h9C5A000000, 1'b0);
    t_read(8'h04, 3, 40'h8142C38000, 1'b1);
    t_read(8'h09, 4, 40'h7FA5015AC0, 1'b1);
    t_reject(8'h04, 2, "R8 id length");
    t_reject(8'h09, 3, "R8 status length");
    t_reject(8'h0A, 0, "R9 zero read");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule